// File: doc/BRIEF.md
# Eight-bit Timer/Counter with Shared Prescaler

This block is an 8-bit up-counter for a small microcontroller. It is advanced either by the instruction-cycle strobe or by edges of an external clock pin, and the source can pass through a programmable divider first. A simple register bus gives access to three registers: the count, an option register that selects the source, the counting edge, the divider owner and the divider ratio, and an interrupt-control register that holds the overflow flag and its enable.

The divider is a single resource. Either it sits in front of this timer, or the neighbouring watchdog takes it over. When the watchdog owns it, the divider is clocked by the watchdog's strobe and only its terminal-count pulse leaves the block. The timer then counts its selected source without division.

A write to the count register discards the next two increments. While the sleep input is high the timer does not count.

Top module: `tick_counter`

## Requirements
- R1: After a synchronous reset the count is 00h, the option register reads FFh, the interrupt-control register reads 00h, and `irq_o` and `psc_tap_o` are 0.
- R2: With option bit 5 = 0 and option bit 3 = 1, the count increments by one at each clock edge where `cyc_en_i` is 1. It never changes by any amount other than 0 or +1 unless the count register is written.
- R3: With option bit 5 = 1 and option bit 4 = 0, a rising edge on `ext_clk_i` is registered through two flip-flops and a third edge-detect stage. The count increments at the third clock edge after the pin is first sampled high.
- R4: With option bit 5 = 1 and option bit 4 = 1, falling edges of `ext_clk_i` are counted instead, with the same latency as in R3.
- R5: With option bit 3 = 0, the timer's source events pass through the divider. Option bits 2:0 = n give one increment per 2^(n+1) events, so 000 gives 1:2 and 111 gives 1:256.
- R6: A write to address 0 loads the count, and the next two increment opportunities are discarded. If a source event arrives in the same cycle, the write wins. When option bit 3 = 0, the write also clears the divider.
- R7: An increment from FFh to 00h sets interrupt-control bit 2. The bit stays set until a write to address 2 clears it, and an overflow in the same cycle as that clearing write leaves it set.
- R8: `irq_o` is 1 exactly when interrupt-control bit 2 and bit 5 are both 1.
- R9: While `sleep_i` is 1 the timer neither counts nor advances the divider.
- R10: With option bit 3 = 1, the divider counts `wdt_src_i` pulses and `psc_tap_o` pulses once per 2^(n+1) pulses, one clock after the terminal pulse. With option bit 3 = 0, `psc_tap_o` stays 0.
- R11: Register addresses are 0 = count, 1 = option, 2 = interrupt control (only bits 5 and 2 are stored; the other bits read 0), and 3 = reads 00h. `bus_rdata_o` shows the addressed register one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_en_i | input | 1 | Instruction-cycle strobe |
| ext_clk_i | input | 1 | Asynchronous external count pin |
| sleep_i | input | 1 | Halts counting while high |
| wdt_src_i | input | 1 | Watchdog strobe, used when the watchdog owns the divider |
| bus_addr_i | input | 2 | Register address |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Registered read data |
| irq_o | output | 1 | Overflow interrupt request |
| psc_tap_o | output | 1 | Divider terminal-count pulse for the watchdog |

## Verification
The bench builds the block with its default parameters: an 8-bit count, an 8-bit divider, a two-flop synchroniser and a two-event inhibit. With these values every divider ratio up to 1:256 and several count roll-overs fit in a short run. They also make the exact placement of a rolling overflow against a clearing write, a load or a sleep window reachable and checkable on every clock.

// File: rtl/tc_pkg.sv
package tc_pkg;
  typedef enum logic [1:0] {
    REG_CNT  = 2'd0,
    REG_OPT  = 2'd1,
    REG_ICTL = 2'd2,
    REG_NONE = 2'd3
  } reg_sel_e;

  localparam int OPT_CS   = 5;
  localparam int OPT_SE   = 4;
  localparam int OPT_PSA  = 3;
  localparam int ICTL_FLG = 2;
  localparam int ICTL_EN  = 5;
endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_i,
  input  logic fall_i,
  output logic edge_o
);
  // chain[STAGES-1] is the newest synchronised sample, chain[STAGES] the previous one
  logic [STAGES:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-1:0], pin_i};
  end

  always_comb begin
    if (fall_i) edge_o = chain[STAGES] & ~chain[STAGES-1];
    else        edge_o = ~chain[STAGES] & chain[STAGES-1];
  end
endmodule

// File: rtl/tc_prescaler.sv
module tc_prescaler #(
  parameter int PS_W  = 8,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic             adv_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             full_o
);
  logic [PS_W-1:0] cnt_q;
  logic [PS_W-1:0] mask;

  // ratio 2^(sel+1): the low sel+1 bits must all be ones
  for (genvar g = 0; g < PS_W; g++) begin : g_mask
    assign mask[g] = (int'(sel_i) >= g);
  end

  assign full_o = adv_i && ((cnt_q & mask) == mask);

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= '0;
    else if (clr_i) cnt_q <= '0;
    else if (adv_i) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tc_count.sv
module tc_count #(
  parameter int DW      = 8,
  parameter int INHIBIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  output logic [DW-1:0] cnt_o,
  output logic          wrap_o
);
  localparam int IW = $clog2(INHIBIT + 1);

  logic [IW-1:0] inh_q;
  logic [DW-1:0] cnt_q;

  assign cnt_o  = cnt_q;
  assign wrap_o = tick_i && !ld_i && (inh_q == '0) && (&cnt_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      inh_q <= '0;
    end else if (ld_i) begin
      cnt_q <= ld_val_i;
      inh_q <= IW'(INHIBIT);
    end else if (tick_i) begin
      if (inh_q != '0) inh_q <= inh_q - 1'b1;
      else             cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int DW          = 8,
  parameter int PS_W        = 8,
  parameter int SEL_W       = 3,
  parameter int SYNC_STAGES = 2,
  parameter int INHIBIT     = 2,
  parameter logic [7:0] OPT_RST = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cyc_en_i,
  input  logic          ext_clk_i,
  input  logic          sleep_i,
  input  logic          wdt_src_i,
  input  logic [1:0]    bus_addr_i,
  input  logic          bus_wr_i,
  input  logic [DW-1:0] bus_wdata_i,
  output logic [DW-1:0] bus_rdata_o,
  output logic          irq_o,
  output logic          psc_tap_o
);
  import tc_pkg::*;

  logic [DW-1:0] opt_q;
  logic          flag_q, en_q, flag_d, en_d;
  logic [DW-1:0] count_q;
  logic          wr_cnt, wr_opt, wr_ictl;
  logic          pin_edge, src_ev, psa;
  logic          ps_adv, ps_clr, ps_full, tick, wrap;
  logic          irq_q, tap_q;
  logic [DW-1:0] rd_mux, rdata_q;

  assign wr_cnt  = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_CNT);
  assign wr_opt  = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_OPT);
  assign wr_ictl = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_ICTL);

  tc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_i (ext_clk_i),
    .fall_i(opt_q[OPT_SE]),
    .edge_o(pin_edge)
  );

  assign psa    = opt_q[OPT_PSA];
  assign src_ev = (opt_q[OPT_CS] ? pin_edge : cyc_en_i) & ~sleep_i;
  assign ps_adv = psa ? wdt_src_i : src_ev;
  assign ps_clr = wr_cnt & ~psa;

  tc_prescaler #(.PS_W(PS_W), .SEL_W(SEL_W)) u_psc (
    .clk   (clk),
    .rst   (rst),
    .clr_i (ps_clr),
    .adv_i (ps_adv),
    .sel_i (opt_q[SEL_W-1:0]),
    .full_o(ps_full)
  );

  assign tick = psa ? src_ev : ps_full;

  tc_count #(.DW(DW), .INHIBIT(INHIBIT)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .tick_i  (tick),
    .ld_i    (wr_cnt),
    .ld_val_i(bus_wdata_i),
    .cnt_o   (count_q),
    .wrap_o  (wrap)
  );

  always_comb begin
    flag_d = flag_q;
    en_d   = en_q;
    if (wr_ictl) begin
      flag_d = bus_wdata_i[ICTL_FLG];
      en_d   = bus_wdata_i[ICTL_EN];
    end
    if (wrap) flag_d = 1'b1;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_sel_e'(bus_addr_i))
      REG_CNT:  rd_mux = count_q;
      REG_OPT:  rd_mux = opt_q;
      REG_ICTL: begin
        rd_mux[ICTL_FLG] = flag_q;
        rd_mux[ICTL_EN]  = en_q;
      end
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      opt_q   <= DW'(OPT_RST);
      flag_q  <= 1'b0;
      en_q    <= 1'b0;
      irq_q   <= 1'b0;
      tap_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      if (wr_opt) opt_q <= bus_wdata_i;
      flag_q  <= flag_d;
      en_q    <= en_d;
      irq_q   <= flag_d & en_d;
      tap_q   <= psa & ps_full;
      rdata_q <= rd_mux;
    end
  end

  assign bus_rdata_o = rdata_q;
  assign irq_o       = irq_q;
  assign psc_tap_o   = tap_q;
endmodule

// File: rtl/tc_checker.sv
module tc_checker #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst,
  input logic          sleep_i,
  input logic [1:0]    bus_addr_i,
  input logic          bus_wr_i,
  input logic [DW-1:0] bus_wdata_i,
  input logic          irq_o,
  input logic          psc_tap_o,
  input logic [DW-1:0] count_q,
  input logic          psa_bit,
  input logic          flag_q,
  input logic          en_q
);
  logic ld;
  assign ld = bus_wr_i && (bus_addr_i == 2'd0);

  assert_load_R6: assert property (@(posedge clk) disable iff (rst)
    ld |=> (count_q == $past(bus_wdata_i)));

  assert_sleep_R9: assert property (@(posedge clk) disable iff (rst)
    (sleep_i && !ld) |=> (count_q == $past(count_q)));

  assert_step_R2: assert property (@(posedge clk) disable iff (rst)
    !ld |=> ((count_q == $past(count_q)) || (count_q == DW'($past(count_q) + 1'b1))));

  assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !(bus_wr_i && bus_addr_i == 2'd2)) |=> flag_q);

  assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
    ((count_q == '0) && ($past(count_q) == '1) && !$past(ld)) |-> flag_q);

  assert_irq_mask_R8: assert property (@(posedge clk) disable iff (rst)
    !en_q |-> !irq_o);

  assert_tap_owner_R10: assert property (@(posedge clk) disable iff (rst)
    !psa_bit |=> !psc_tap_o);
endmodule

bind tick_counter tc_checker #(.DW(DW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .sleep_i    (sleep_i),
  .bus_addr_i (bus_addr_i),
  .bus_wr_i   (bus_wr_i),
  .bus_wdata_i(bus_wdata_i),
  .irq_o      (irq_o),
  .psc_tap_o  (psc_tap_o),
  .count_q    (count_q),
  .psa_bit    (opt_q[3]),
  .flag_q     (flag_q),
  .en_q       (en_q)
);

// File: tb/tb_tick_counter.sv
`timescale 1ns/1ps
module tb_tick_counter;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_en_i = 1'b0, ext_clk_i = 1'b0, sleep_i = 1'b0, wdt_src_i = 1'b0;
  logic [1:0] bus_addr_i = 2'd0;
  logic       bus_wr_i = 1'b0;
  logic [7:0] bus_wdata_i = 8'h00;
  logic [7:0] bus_rdata_o;
  logic       irq_o, psc_tap_o;

  always #5 clk = ~clk;

  tick_counter dut (
    .clk(clk), .rst(rst), .cyc_en_i(cyc_en_i), .ext_clk_i(ext_clk_i),
    .sleep_i(sleep_i), .wdt_src_i(wdt_src_i), .bus_addr_i(bus_addr_i),
    .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o),
    .irq_o(irq_o), .psc_tap_o(psc_tap_o)
  );

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  logic  pin_lvl = 1'b0;

  // behavioural reference state
  int m_cnt = 0, m_inh = 0, m_pcnt = 0;
  int m_opt = 255, m_flag = 0, m_en = 0;
  int m_irq = 0, m_tap = 0, m_rd = 0;
  int pin_hist[$] = '{0, 0, 0};

  function automatic int bitof(int v, int b);
    return (v >> b) & 1;
  endfunction

  task automatic model(input int ce, input int pin, input int slp, input int ws,
                       input int a, input int wr, input int d);
    int s2, s3, ev, src, psa, ratio, ps_in, full, tick, wrap;
    s2 = pin_hist[1];
    s3 = pin_hist[2];
    if (bitof(m_opt, 4) == 1) ev = (s3 == 1 && s2 == 0) ? 1 : 0;
    else                      ev = (s3 == 0 && s2 == 1) ? 1 : 0;
    src = (bitof(m_opt, 5) == 1) ? ev : ce;
    if (slp != 0) src = 0;
    psa   = bitof(m_opt, 3);
    ratio = 2 << (m_opt & 7);
    case (a)
      0: m_rd = m_cnt;
      1: m_rd = m_opt;
      2: m_rd = (m_flag << 2) | (m_en << 5);
      default: m_rd = 0;
    endcase
    ps_in = (psa == 1) ? ws : src;
    full  = (ps_in != 0 && ((m_pcnt + 1) % ratio) == 0) ? 1 : 0;
    tick  = (psa == 1) ? src : full;
    if (wr != 0 && a == 0 && psa == 0) m_pcnt = 0;
    else if (ps_in != 0)               m_pcnt = (m_pcnt + 1) % 256;
    wrap = 0;
    if (wr != 0 && a == 0) begin
      m_cnt = d;
      m_inh = 2;
    end else if (tick != 0) begin
      if (m_inh > 0) m_inh--;
      else begin
        if (m_cnt == 255) wrap = 1;
        m_cnt = (m_cnt + 1) % 256;
      end
    end
    if (wr != 0 && a == 2) begin
      m_flag = bitof(d, 2);
      m_en   = bitof(d, 5);
    end
    if (wrap != 0) m_flag = 1;
    if (wr != 0 && a == 1) m_opt = d;
    m_irq = m_flag & m_en;
    m_tap = psa & full;
    pin_hist.push_front(pin);
    void'(pin_hist.pop_back());
  endtask

  task automatic step(input logic ce, input logic pin, input logic slp, input logic ws,
                      input logic [1:0] a, input logic wr, input logic [7:0] d);
    cyc_en_i = ce; ext_clk_i = pin; sleep_i = slp; wdt_src_i = ws;
    bus_addr_i = a; bus_wr_i = wr; bus_wdata_i = d;
    @(posedge clk);
    model(int'(ce), int'(pin), int'(slp), int'(ws), int'(a), int'(wr), int'(d));
    @(negedge clk);
    checks++;
    if (bus_rdata_o !== 8'(m_rd) || irq_o !== 1'(m_irq) || psc_tap_o !== 1'(m_tap)) begin
      fails++;
      $display("FAIL %s: rdata=%02h irq=%0b tap=%0b expected rdata=%02h irq=%0b tap=%0b",
               cur_req, bus_rdata_o, irq_o, psc_tap_o, 8'(m_rd), 1'(m_irq), 1'(m_tap));
    end
  endtask

  task automatic wreg(input logic [1:0] a, input logic [7:0] d);
    step(1'b0, pin_lvl, 1'b0, 1'b0, a, 1'b1, d);
  endtask

  task automatic idle(input logic [1:0] a, input int n);
    for (int i = 0; i < n; i++) step(1'b0, pin_lvl, 1'b0, 1'b0, a, 1'b0, 8'h00);
  endtask

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    cur_req = "R1";
    idle(2'd0, 2); idle(2'd1, 2); idle(2'd2, 2);

    cur_req = "R11";
    wreg(2'd1, 8'hA5); idle(2'd1, 2); idle(2'd3, 2);
    wreg(2'd1, 8'h08); idle(2'd1, 2);

    cur_req = "R2";
    for (int i = 0; i < 30; i++) step(i % 3 == 0, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);

    cur_req = "R6";
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'h10);
    for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    wreg(2'd0, 8'h40);
    for (int i = 0; i < 12; i++) step(i % 4 == 1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);

    cur_req = "R5";
    wreg(2'd1, 8'h01);
    for (int i = 0; i < 40; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b1, 8'h00);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    wreg(2'd1, 8'h07);
    for (int i = 0; i < 600; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    wreg(2'd1, 8'h00);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);

    cur_req = "R3";
    wreg(2'd1, 8'h28);
    for (int i = 0; i < 60; i++) begin
      if (i % 5 == 0) pin_lvl = ~pin_lvl;
      step(i % 2 == 0, pin_lvl, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    end

    cur_req = "R4";
    wreg(2'd1, 8'h38);
    for (int i = 0; i < 60; i++) begin
      if (i % 4 == 0) pin_lvl = ~pin_lvl;
      step(1'b1, pin_lvl, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    end

    cur_req = "R9";
    wreg(2'd1, 8'h08);
    for (int i = 0; i < 20; i++) step(1'b1, pin_lvl, 1'b1, 1'b0, 2'd0, 1'b0, 8'h00);
    for (int i = 0; i < 5; i++)  step(1'b1, pin_lvl, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    wreg(2'd1, 8'h21);
    for (int i = 0; i < 30; i++) begin
      if (i % 3 == 0) pin_lvl = ~pin_lvl;
      step(1'b1, pin_lvl, i < 20, 1'b0, 2'd0, 1'b0, 8'h00);
    end

    cur_req = "R7";
    wreg(2'd1, 8'h08);
    wreg(2'd2, 8'h20);
    wreg(2'd0, 8'hFA);
    for (int i = 0; i < 12; i++) step(1'b1, pin_lvl, 1'b0, 1'b0, 2'd0, 1'b0, 8'h00);
    idle(2'd2, 3);
    wreg(2'd2, 8'h00);
    wreg(2'd0, 8'hFD);
    for (int i = 0; i < 8; i++) step(1'b1, pin_lvl, 1'b0, 1'b0, 2'd2, 1'b1, 8'h20);
    idle(2'd2, 3);

    cur_req = "R8";
    wreg(2'd2, 8'h04); idle(2'd2, 2);
    wreg(2'd2, 8'h24); idle(2'd2, 2);
    wreg(2'd2, 8'h20); idle(2'd2, 2);

    cur_req = "R10";
    wreg(2'd1, 8'h0A);
    for (int i = 0; i < 40; i++) step(1'b1, pin_lvl, 1'b0, i % 2 == 0, 2'd0, 1'b0, 8'h00);
    wreg(2'd1, 8'h02);
    for (int i = 0; i < 20; i++) step(1'b1, pin_lvl, 1'b0, 1'b1, 2'd0, 1'b0, 8'h00);

    cur_req = "R2";
    for (int i = 0; i < 400; i++) begin
      logic [1:0] a;
      logic       wr;
      logic [7:0] d;
      a  = 2'($urandom_range(0, 3));
      wr = ($urandom_range(0, 15) == 0);
      d  = 8'($urandom);
      if (wr && a == 2'd1) d = d & 8'hFB;
      if ($urandom_range(0, 3) == 0) pin_lvl = ~pin_lvl;
      step(1'($urandom), pin_lvl, ($urandom_range(0, 7) == 0), 1'($urandom), a, wr, d);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule